// File: doc/BRIEF.md
# Byte-Fed CRC Calculator with Selectable Polynomial

This block computes a cyclic redundancy check over a byte stream of any length. The host writes one byte per cycle to the data port. The block folds that byte into a running CRC register in the same clock cycle, so the new value is ready on the next cycle. The generator polynomial is chosen at run time from three fixed options: one 8-bit and two 16-bit. The bit order is also selectable. In LSB-first order, bit 0 of each byte is processed first and the register shifts right against the reflected polynomial. In MSB-first order, bit 7 is processed first and the register shifts left against the normal polynomial.

The active polynomial is held as a three-state mode machine. The states are `ST_POLY8`, `ST_POLY16_A` and `ST_POLY16_B`. A configuration write with a valid code moves the machine to the state that code names, from any state to any state. A transition to a different state clears the CRC register. A write that names the current state is a self-loop and keeps the register. Code 3 causes no transition. The result register can be written to load a seed, and it is always readable on `crc_out`.

Top module: `crc_calc`

## Requirements
- R1: After reset, `crc_out` is 0, `poly_sel_out` is 0 (8-bit polynomial) and `lsb_out` is 0 (MSB-first).
- R2: Polynomial code 0 selects x^8+x^2+x+1 (normal 0x07, reflected 0xE0). In MSB-first order with seed 0, the ASCII bytes "123456789" give 0xF4.
- R3: Code 1 selects x^16+x^15+x^2+1 (normal 0x8005). With seed 0, "123456789" gives 0xFEE8 MSB-first.
- R4: Code 2 selects x^16+x^12+x^5+1 (normal 0x1021). With seed 0, "123456789" gives 0x31C3 MSB-first.
- R5: With `cfg_lsb`=1, each byte is folded in bit 0 first, shifting right against the reflected polynomial. With seed 0, "123456789" gives 0xBB3D for code 1 and 0x2189 for code 2.
- R6: Every `din_we` cycle folds one byte, and the updated CRC appears on `crc_out` on the following cycle. Back-to-back bytes are all taken.
- R7: A `res_we` write loads `res_wdata` as the new CRC value. Under code 0, only bits [7:0] are kept.
- R8: While code 0 is active, `crc_out[15:8]` reads 0.
- R9: A configuration write naming a polynomial different from the active one clears the CRC to 0. A write with the same polynomial, including one that changes only the bit order, keeps the value.
- R10: A configuration write with code 3 is ignored: polynomial, bit order and CRC all stay unchanged.
- R11: In a cycle with several writes, a clearing configuration write wins over a seed write, and a seed write wins over a data byte. A data byte or seed in the same cycle as a non-clearing configuration write uses the settings that were in force before that write.
- R12: In a cycle with no write, `crc_out`, `poly_sel_out` and `lsb_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_poly | input | 2 | Polynomial code: 0 = 8-bit, 1 = 0x8005, 2 = 0x1021, 3 = ignored |
| cfg_lsb | input | 1 | Bit order written with the configuration: 1 = LSB-first |
| res_we | input | 1 | Seed write strobe for the CRC register |
| res_wdata | input | 16 | Seed value |
| din_we | input | 1 | Data byte strobe |
| din | input | 8 | Data byte |
| crc_out | output | 16 | Current CRC register value |
| poly_sel_out | output | 2 | Active polynomial code |
| lsb_out | output | 1 | Active bit order |

## Verification
The hardest case to reach is a cycle that raises two or three of the write strobes together. Two things decide the result there: which write has priority, and whether the byte is folded with the old settings or the new ones. A stream of single-strobe writes never reaches that case. The stimulus therefore drives such collisions directly: a polynomial change together with a seed and a byte, a same-polynomial bit-order flip together with a byte, and a seed together with a byte. A random phase then draws each strobe on its own, so such overlaps also occur at random across all three polynomials and both orders. Every cycle is compared with a bit-serial model that feeds one bit at a time, which is a different formulation from the unrolled byte engine.

// File: rtl/crc_calc_pkg.sv
package crc_calc_pkg;

    localparam int CRC_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int NARROW_W = 8;
    localparam int CODE_W   = 2;

    typedef enum logic [CODE_W-1:0] {
        ST_POLY8    = 2'd0,
        ST_POLY16_A = 2'd1,
        ST_POLY16_B = 2'd2
    } poly_state_e;

    localparam logic [CODE_W-1:0] CODE_RESERVED = 2'd3;

    localparam logic [CRC_W-1:0] GEN_POLY8    = 16'h0007;
    localparam logic [CRC_W-1:0] GEN_POLY16_A = 16'h8005;
    localparam logic [CRC_W-1:0] GEN_POLY16_B = 16'h1021;

    // Mirror the low w bits of p; bits above w come out zero.
    function automatic logic [CRC_W-1:0] mirror_bits(input logic [CRC_W-1:0] p, input int w);
        logic [CRC_W-1:0] r;
        r = '0;
        for (int i = 0; i < CRC_W; i++) begin
            if (i < w) r[w-1-i] = p[i];
        end
        return r;
    endfunction

    localparam logic [CRC_W-1:0] REF_POLY8    = mirror_bits(GEN_POLY8, NARROW_W);
    localparam logic [CRC_W-1:0] REF_POLY16_A = mirror_bits(GEN_POLY16_A, CRC_W);
    localparam logic [CRC_W-1:0] REF_POLY16_B = mirror_bits(GEN_POLY16_B, CRC_W);

endpackage

// File: rtl/crc_mode_fsm.sv
module crc_mode_fsm
    import crc_calc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CODE_W-1:0]       cfg_poly,
    input  logic                    cfg_lsb,
    output poly_state_e             state_o,
    output logic                    lsb_o,
    output logic                    clear_o,
    output logic                    narrow_o,
    output logic [CRC_W-1:0]        poly_o,
    output logic [CRC_W-1:0]        refl_o,
    output logic [CRC_W-1:0]        mask_o
);

    poly_state_e state_q, state_d;
    logic        lsb_q, lsb_d;
    logic        code_ok;

    assign code_ok = cfg_we && (cfg_poly != CODE_RESERVED);

    // Next-state logic: any valid code moves to its state.
    always_comb begin
        state_d = state_q;
        lsb_d   = lsb_q;
        clear_o = 1'b0;
        if (code_ok) begin
            lsb_d = cfg_lsb;
            unique case (cfg_poly)
                2'd0:    state_d = ST_POLY8;
                2'd1:    state_d = ST_POLY16_A;
                2'd2:    state_d = ST_POLY16_B;
                default: state_d = state_q;
            endcase
            clear_o = (state_d != state_q);
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POLY8;
            lsb_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            lsb_q   <= lsb_d;
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        unique case (state_q)
            ST_POLY8: begin
                narrow_o = 1'b1;
                poly_o   = GEN_POLY8;
                refl_o   = REF_POLY8;
                mask_o   = {{(CRC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
            end
            ST_POLY16_A: begin
                narrow_o = 1'b0;
                poly_o   = GEN_POLY16_A;
                refl_o   = REF_POLY16_A;
                mask_o   = {CRC_W{1'b1}};
            end
            ST_POLY16_B: begin
                narrow_o = 1'b0;
                poly_o   = GEN_POLY16_B;
                refl_o   = REF_POLY16_B;
                mask_o   = {CRC_W{1'b1}};
            end
            default: begin
                narrow_o = 1'b1;
                poly_o   = GEN_POLY8;
                refl_o   = REF_POLY8;
                mask_o   = {{(CRC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
            end
        endcase
    end

    assign state_o = state_q;
    assign lsb_o   = lsb_q;

    // R10
    reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_poly == CODE_RESERVED) |=> ($stable(state_q) && $stable(lsb_q)));

    // R12
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(state_q) && $stable(lsb_q)));

endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine #(
    parameter int CRC_W    = 16,
    parameter int BYTE_W   = 8,
    parameter int NARROW_W = 8
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              narrow_i,
    input  logic              lsb_i,
    input  logic [CRC_W-1:0]  poly_i,
    input  logic [CRC_W-1:0]  refl_i,
    output logic [CRC_W-1:0]  crc_o
);

    localparam int SH = CRC_W - NARROW_W;

    logic [CRC_W-1:0] msb_chain [0:BYTE_W];
    logic [CRC_W-1:0] lsb_chain [0:BYTE_W];
    logic [CRC_W-1:0] poly_al;
    logic [CRC_W-1:0] crc_al;
    logic [CRC_W-1:0] data_ext;
    logic [CRC_W-1:0] msb_out;

    assign data_ext = {{(CRC_W-BYTE_W){1'b0}}, data_i};

    // The narrow polynomial runs MSB-first in the top bits of the chain.
    assign poly_al = narrow_i ? (poly_i << SH) : poly_i;
    assign crc_al  = narrow_i ? (crc_i << SH)  : crc_i;

    assign msb_chain[0] = crc_al ^ (data_ext << (CRC_W - BYTE_W));
    assign lsb_chain[0] = crc_i ^ data_ext;

    for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
        assign msb_chain[g+1] = msb_chain[g][CRC_W-1] ? ((msb_chain[g] << 1) ^ poly_al)
                                                      :  (msb_chain[g] << 1);
        assign lsb_chain[g+1] = lsb_chain[g][0] ? ((lsb_chain[g] >> 1) ^ refl_i)
                                                :  (lsb_chain[g] >> 1);
    end

    assign msb_out = narrow_i ? (msb_chain[BYTE_W] >> SH) : msb_chain[BYTE_W];
    assign crc_o   = lsb_i ? lsb_chain[BYTE_W] : msb_out;

endmodule

// File: rtl/crc_calc.sv
module crc_calc
    import crc_calc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_poly,
    input  logic        cfg_lsb,
    input  logic        res_we,
    input  logic [15:0] res_wdata,
    input  logic        din_we,
    input  logic [7:0]  din,
    output logic [15:0] crc_out,
    output logic [1:0]  poly_sel_out,
    output logic        lsb_out
);

    poly_state_e      state;
    logic             lsb_mode;
    logic             clear;
    logic             narrow;
    logic [CRC_W-1:0] poly_n;
    logic [CRC_W-1:0] poly_r;
    logic [CRC_W-1:0] mask;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;

    crc_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_poly (cfg_poly),
        .cfg_lsb  (cfg_lsb),
        .state_o  (state),
        .lsb_o    (lsb_mode),
        .clear_o  (clear),
        .narrow_o (narrow),
        .poly_o   (poly_n),
        .refl_o   (poly_r),
        .mask_o   (mask)
    );

    crc_byte_engine #(
        .CRC_W    (CRC_W),
        .BYTE_W   (BYTE_W),
        .NARROW_W (NARROW_W)
    ) u_engine (
        .crc_i    (crc_q),
        .data_i   (din),
        .narrow_i (narrow),
        .lsb_i    (lsb_mode),
        .poly_i   (poly_n),
        .refl_i   (poly_r),
        .crc_o    (crc_next)
    );

    // Priority: polynomial change clears, then seed, then data byte.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clear) begin
            crc_q <= '0;
        end else if (res_we) begin
            crc_q <= res_wdata & mask;
        end else if (din_we) begin
            crc_q <= crc_next;
        end
    end

    assign crc_out      = crc_q;
    assign poly_sel_out = state;
    assign lsb_out      = lsb_mode;

    // R8
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poly_sel_out == 2'd0) |-> (crc_out[15:8] == 8'h00));

    // R9
    poly_change_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_poly != 2'd3 && cfg_poly != poly_sel_out) |=> (crc_out == '0));

    // R7
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && !(cfg_we && cfg_poly != 2'd3 && cfg_poly != poly_sel_out))
        |=> (crc_out == ($past(res_wdata) & ((poly_sel_out == 2'd0) ? 16'h00FF : 16'hFFFF))));

    // R12
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !res_we && !din_we) |=> $stable(crc_out));

endmodule

// File: tb/crc_calc_test.sv
`timescale 1ns/1ps
module crc_calc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_poly = 2'd0;
    logic        cfg_lsb = 1'b0;
    logic        res_we = 1'b0;
    logic [15:0] res_wdata = 16'h0;
    logic        din_we = 1'b0;
    logic [7:0]  din = 8'h0;
    logic [15:0] crc_out;
    logic [1:0]  poly_sel_out;
    logic        lsb_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_crc;
    logic [1:0]  m_poly;
    logic        m_lsb;

    crc_calc uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_poly     (cfg_poly),
        .cfg_lsb      (cfg_lsb),
        .res_we       (res_we),
        .res_wdata    (res_wdata),
        .din_we       (din_we),
        .din          (din),
        .crc_out      (crc_out),
        .poly_sel_out (poly_sel_out),
        .lsb_out      (lsb_out)
    );

    always #2 clk = ~clk;

    // Bit-serial reference: one bit per step.
    function automatic logic [15:0] ref_byte(input logic [15:0] c, input logic [7:0] d,
                                             input logic [1:0] code, input logic lsb);
        int w;
        logic [15:0] p, rp, mk;
        logic fb;
        w  = (code == 2'd0) ? 8 : 16;
        p  = (code == 2'd0) ? 16'h0007 : (code == 2'd1) ? 16'h8005 : 16'h1021;
        mk = (w == 8) ? 16'h00FF : 16'hFFFF;
        rp = '0;
        for (int i = 0; i < w; i++) rp[w-1-i] = p[i];
        if (lsb) begin
            for (int i = 0; i < 8; i++) begin
                fb = c[0] ^ d[i];
                c  = c >> 1;
                if (fb) c = c ^ rp;
            end
        end else begin
            for (int i = 7; i >= 0; i--) begin
                fb = c[w-1] ^ d[i];
                c  = (c << 1) & mk;
                if (fb) c = c ^ p;
            end
        end
        return c;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Drive one cycle of writes, advance the model, compare all outputs.
    task automatic cycle(input string tag,
                         input logic cw, input logic [1:0] cp, input logic cl,
                         input logic rw, input logic [15:0] rd,
                         input logic dw, input logic [7:0] dd);
        logic [15:0] nxt;
        bit clr;
        cfg_we = cw; cfg_poly = cp; cfg_lsb = cl;
        res_we = rw; res_wdata = rd;
        din_we = dw; din = dd;
        @(negedge clk);
        cfg_we = 1'b0; res_we = 1'b0; din_we = 1'b0;
        clr = 1'b0;
        nxt = m_crc;
        if (rw)      nxt = rd & ((m_poly == 2'd0) ? 16'h00FF : 16'hFFFF);
        else if (dw) nxt = ref_byte(m_crc, dd, m_poly, m_lsb);
        if (cw && cp != 2'd3) begin
            if (cp != m_poly) clr = 1'b1;
            m_poly = cp;
            m_lsb  = cl;
        end
        m_crc = clr ? 16'h0 : nxt;
        check({tag, " crc"},  crc_out, m_crc);
        check({tag, " poly"}, {14'h0, poly_sel_out}, {14'h0, m_poly});
        check({tag, " lsb"},  {15'h0, lsb_out}, {15'h0, m_lsb});
    endtask

    task automatic feed_digits(input string tag);
        string s = "123456789";
        for (int i = 0; i < 9; i++) cycle(tag, 0, 0, 0, 0, 0, 1, s[i]);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        m_crc = 0; m_poly = 0; m_lsb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 crc", crc_out, 16'h0);
        check("R1 poly", {14'h0, poly_sel_out}, 16'h0);
        check("R1 lsb", {15'h0, lsb_out}, 16'h0);

        // R2 8-bit, MSB-first; R6 back-to-back bytes checked each cycle
        feed_digits("R6 R2");
        check("R2 known", crc_out, 16'h00F4);
        check("R8 upper", {8'h0, crc_out[15:8]}, 16'h0);

        // R9 polynomial change clears; R3 known value
        cycle("R9 clear", 1, 2'd1, 0, 0, 0, 0, 0);
        check("R9 zero", crc_out, 16'h0);
        feed_digits("R3");
        check("R3 known", crc_out, 16'hFEE8);

        // R9 order-only change keeps value; R5 LSB-first
        cycle("R9 keep", 1, 2'd1, 1, 0, 0, 0, 0);
        check("R9 kept", crc_out, 16'hFEE8);
        cycle("R7 seed0", 0, 0, 0, 1, 16'h0, 0, 0);
        feed_digits("R5");
        check("R5 known 8005", crc_out, 16'hBB3D);

        // R4 second 16-bit polynomial
        cycle("R4 sel", 1, 2'd2, 0, 0, 0, 0, 0);
        feed_digits("R4");
        check("R4 known", crc_out, 16'h31C3);
        cycle("R5 sel", 1, 2'd2, 1, 1, 16'h0, 0, 0);
        feed_digits("R5");
        check("R5 known 1021", crc_out, 16'h2189);

        // R7 nonzero seed
        cycle("R7 order", 1, 2'd2, 0, 0, 0, 0, 0);
        cycle("R7 seed", 0, 0, 0, 1, 16'hFFFF, 0, 0);
        feed_digits("R7");
        check("R7 known", crc_out, 16'h29B1);

        // R7 seed truncated under 8-bit polynomial
        cycle("R7 sel8", 1, 2'd0, 0, 0, 0, 0, 0);
        cycle("R7 narrow", 0, 0, 0, 1, 16'hABCD, 0, 0);
        check("R7 narrow", crc_out, 16'h00CD);

        // R10 reserved code ignored
        cycle("R10", 1, 2'd3, 1, 0, 0, 0, 0);
        check("R10 crc", crc_out, 16'h00CD);
        check("R10 poly", {14'h0, poly_sel_out}, 16'h0);

        // R11 collisions
        cycle("R11 clear wins", 1, 2'd1, 0, 1, 16'h1234, 1, 8'h55);
        check("R11 clear", crc_out, 16'h0);
        cycle("R11 seed wins", 0, 0, 0, 1, 16'h4321, 1, 8'hAA);
        check("R11 seed", crc_out, 16'h4321);
        cycle("R11 old order", 1, 2'd1, 1, 0, 0, 1, 8'h3C);
        check("R11 old order", crc_out, ref_byte(16'h4321, 8'h3C, 2'd1, 1'b0));

        // R12 idle hold
        repeat (4) cycle("R12", 0, 0, 0, 0, 0, 0, 0);

        // Random mix
        r = $urandom(32'd20240611);
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            a = $urandom();
            cycle("R6 rand",
                  a[3:0] == 4'd0, a[5:4], a[6],
                  a[9:7] == 3'd0, a[31:16],
                  a[10] | a[11], a[19:12]);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule